// File: doc/BRIEF.md
# Debug Instruction Transfer Gate

An external debugger hands 32-bit instruction words to a halted core through this gate, one word at a time. Before a write is passed on, the gate checks four things in order. It checks the power and lock status, the sticky error flag, the software lock (for memory-mapped accesses only), and whether the core is halted. A write that passes these checks is then tested against the instruction-ready flag and the memory-access mode. If either one forbids the write, the gate records a sticky overrun and error pair instead of stalling the bus.

An accepted word goes to the core over a valid/done handshake and stays presented until the core answers. In compressed-instruction mode the word goes out as two halfwords, low half first, each with its own done. A done can carry an abort, which sets the error flag. Only one instruction is ever outstanding. The overrun and error flags clear only on an explicit clear strobe.

Top module: `dbg_itr_gate`

## Requirements
- R1: When `dbg_wr` is high and the status bits {`stat_lock`,`stat_oslock`,`stat_pwr`} differ from 3'b001, `dbg_wr_err` is high in that same cycle, and the write neither issues nor sets any flag.
- R2: A write with good status is dropped with no effect when `itr_err` is already 1, or when `dbg_mmap` and `sw_lock` are both 1.
- R3: A write with good status that is not dropped under R2 has no effect while `core_halted` is 0.
- R4: A write that passes R1 to R3 while `itr_ready` is 0 or `mem_acc_mode` is 1 sets `itr_ovr` and `itr_err` at the next clock edge and issues nothing.
- R5: Any other write is accepted. After the next edge, `core_issue_valid` is 1 and `itr_ready` is 0.
- R6: In full-word mode (`cmp_mode` 0 when the write is accepted), `core_issue_word` carries the whole word with `core_issue_part` 0. A done without abort ends the issue, and after that edge `core_issue_valid` is 0 and `itr_ready` is 1.
- R7: In compressed mode (`cmp_mode` 1 when the write is accepted), the first presentation is {16'h0, word[15:0]} with part 0. After its done it becomes {16'h0, word[31:16]} with part 1, and a second done ends the issue.
- R8: A done with `core_abort` high ends the issue at once, even during the first halfword, sets `itr_err` and returns `itr_ready` to 1.
- R9: `clr_strobe` clears `itr_ovr` and `itr_err` at the next edge. An event that sets a flag at the same edge takes priority.
- R10: After reset, `itr_ready` is 1, both flags are 0 and nothing is issued. A done that arrives while nothing is issued is ignored.
- R11: While `core_issue_valid` is high and no done arrives, the valid, word and part outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_wdata | input | 32 | Instruction word |
| dbg_mmap | input | 1 | Write arrived through the memory-mapped path |
| stat_lock | input | 1 | Debug lock status bit |
| stat_oslock | input | 1 | OS lock status bit |
| stat_pwr | input | 1 | Core powered-up status bit |
| sw_lock | input | 1 | Software lock engaged |
| core_halted | input | 1 | Core is in debug halt |
| mem_acc_mode | input | 1 | Memory-access mode active |
| cmp_mode | input | 1 | Compressed-instruction mode |
| clr_strobe | input | 1 | Clears the overrun and error flags |
| core_done | input | 1 | One-cycle completion pulse from the core |
| core_abort | input | 1 | Qualifies `core_done` as an abort |
| dbg_wr_err | output | 1 | Bus error response for the current write |
| core_issue_valid | output | 1 | Instruction presented to the core |
| core_issue_word | output | 32 | Word or halfword being presented |
| core_issue_part | output | 1 | Halfword index, 0 = low half |
| itr_ready | output | 1 | Gate can take another instruction |
| itr_ovr | output | 1 | Sticky instruction overrun |
| itr_err | output | 1 | Sticky error |

## Verification
The bus error is combinational and is due in the same cycle as the write. Every other result is due exactly one clock edge after its cause: issue, ready, the flags, the halfword advance and the end of an issue after done. The bench drives inputs just after a falling edge. A behavioural model advances at each rising edge from the inputs it has seen. All outputs are compared with that model at the next falling edge, so each result is checked in the cycle it falls due.

// File: rtl/dbg_itr_pkg.sv
package dbg_itr_pkg;

  typedef enum logic [1:0] {
    ACC_BUSERR  = 2'd0,
    ACC_DROP    = 2'd1,
    ACC_OVERRUN = 2'd2,
    ACC_ISSUE   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    IS_IDLE = 2'd0,
    IS_LOW  = 2'd1,
    IS_HIGH = 2'd2
  } issue_st_e;

  typedef struct packed {
    logic lock;
    logic oslock;
    logic pwr;
  } pwr_stat_t;

  localparam pwr_stat_t STAT_OK = '{lock: 1'b0, oslock: 1'b0, pwr: 1'b1};

  // Order of the checks matters: bus error first, then drops, then overrun.
  function automatic acc_kind_e classify(
    input pwr_stat_t st,
    input logic      err_sticky,
    input logic      mmap,
    input logic      swl,
    input logic      halted,
    input logic      ready,
    input logic      mam
  );
    if (st != STAT_OK)           return ACC_BUSERR;
    if (err_sticky)              return ACC_DROP;
    if (mmap && swl)             return ACC_DROP;
    if (!halted)                 return ACC_DROP;
    if (!ready || mam)           return ACC_OVERRUN;
    return ACC_ISSUE;
  endfunction

  // Pick the presented value: whole word, or one zero-extended halfword.
  function automatic logic [31:0] present_word(
    input logic [31:0] w,
    input logic        cmp,
    input logic        upper
  );
    if (!cmp)  return w;
    if (upper) return {16'h0000, w[31:16]};
    return {16'h0000, w[15:0]};
  endfunction

endpackage

// File: rtl/dbg_itr_classify.sv
module dbg_itr_classify
  import dbg_itr_pkg::*;
(
  input  logic      wr,
  input  pwr_stat_t stat,
  input  logic      err_sticky,
  input  logic      mmap,
  input  logic      swl,
  input  logic      halted,
  input  logic      ready,
  input  logic      mam,
  output logic      ev_buserr,
  output logic      ev_overrun,
  output logic      ev_issue
);
  acc_kind_e kind;

  always_comb begin
    kind       = classify(stat, err_sticky, mmap, swl, halted, ready, mam);
    ev_buserr  = wr && (kind == ACC_BUSERR);
    ev_overrun = wr && (kind == ACC_OVERRUN);
    ev_issue   = wr && (kind == ACC_ISSUE);
  end
endmodule

// File: rtl/dbg_itr_issue.sv
module dbg_itr_issue
  import dbg_itr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_issue,
  input  logic [DW-1:0] wdata,
  input  logic          cmp_in,
  input  logic          done,
  input  logic          abort,
  output logic          issue_valid,
  output logic [DW-1:0] issue_word,
  output logic          issue_part,
  output logic          ev_finish,
  output logic          ev_abort
);
  issue_st_e     st_q, st_d;
  logic [DW-1:0] word_q;
  logic          cmp_q;
  logic          busy;

  assign busy      = (st_q != IS_IDLE);
  assign ev_abort  = busy && done && abort;
  assign ev_finish = busy && done &&
                     (abort || !cmp_q || (st_q == IS_HIGH));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      IS_IDLE: if (ev_issue) st_d = IS_LOW;
      IS_LOW:  if (done) st_d = (abort || !cmp_q) ? IS_IDLE : IS_HIGH;
      IS_HIGH: if (done) st_d = IS_IDLE;
      default: st_d = IS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IS_IDLE;
      word_q <= '0;
      cmp_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_issue && !busy) begin
        word_q <= wdata;
        cmp_q  <= cmp_in;
      end
    end
  end

  assign issue_valid = busy;
  assign issue_part  = (st_q == IS_HIGH);
  assign issue_word  = busy ? present_word(word_q, cmp_q, issue_part) : '0;

  assert_issue_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !done) |=> (issue_valid && $stable(issue_word) && $stable(issue_part)));

  assert_part_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_part) |-> $past(issue_valid && done && !abort));

  assert_abort_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !issue_valid);
endmodule

// File: rtl/dbg_itr_flags.sv
module dbg_itr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_issue,
  input  logic ev_overrun,
  input  logic ev_finish,
  input  logic ev_abort,
  input  logic clr,
  output logic ready,
  output logic ovr,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      ovr   <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (ev_issue)       ready <= 1'b0;
      else if (ev_finish) ready <= 1'b1;
      if (ev_overrun)     ovr <= 1'b1;
      else if (clr)       ovr <= 1'b0;
      if (ev_overrun || ev_abort) err <= 1'b1;
      else if (clr)               err <= 1'b0;
    end
  end

  assert_ovr_with_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> (ovr && err));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_overrun && !ev_abort) |=> (!ovr && !err));
endmodule

// File: rtl/dbg_itr_gate.sv
module dbg_itr_gate
  import dbg_itr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_wr,
  input  logic [DW-1:0] dbg_wdata,
  input  logic          dbg_mmap,
  input  logic          stat_lock,
  input  logic          stat_oslock,
  input  logic          stat_pwr,
  input  logic          sw_lock,
  input  logic          core_halted,
  input  logic          mem_acc_mode,
  input  logic          cmp_mode,
  input  logic          clr_strobe,
  input  logic          core_done,
  input  logic          core_abort,
  output logic          dbg_wr_err,
  output logic          core_issue_valid,
  output logic [DW-1:0] core_issue_word,
  output logic          core_issue_part,
  output logic          itr_ready,
  output logic          itr_ovr,
  output logic          itr_err
);
  pwr_stat_t stat;
  logic ev_buserr, ev_overrun, ev_issue, ev_finish, ev_abort;

  assign stat = '{lock: stat_lock, oslock: stat_oslock, pwr: stat_pwr};

  dbg_itr_classify u_cls (
    .wr(dbg_wr), .stat(stat), .err_sticky(itr_err), .mmap(dbg_mmap),
    .swl(sw_lock), .halted(core_halted), .ready(itr_ready), .mam(mem_acc_mode),
    .ev_buserr(ev_buserr), .ev_overrun(ev_overrun), .ev_issue(ev_issue)
  );

  dbg_itr_issue #(.DW(DW)) u_iss (
    .clk(clk), .rst_n(rst_n), .ev_issue(ev_issue), .wdata(dbg_wdata),
    .cmp_in(cmp_mode), .done(core_done), .abort(core_abort),
    .issue_valid(core_issue_valid), .issue_word(core_issue_word),
    .issue_part(core_issue_part), .ev_finish(ev_finish), .ev_abort(ev_abort)
  );

  dbg_itr_flags u_flg (
    .clk(clk), .rst_n(rst_n), .ev_issue(ev_issue), .ev_overrun(ev_overrun),
    .ev_finish(ev_finish), .ev_abort(ev_abort), .clr(clr_strobe),
    .ready(itr_ready), .ovr(itr_ovr), .err(itr_err)
  );

  assign dbg_wr_err = ev_buserr;

  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_issue_valid |-> !itr_ready);

  assert_buserr_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buserr |=> !$rose(core_issue_valid) && !$rose(itr_ovr));

  assert_overrun_no_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> !$rose(core_issue_valid));
endmodule

// File: tb/dbg_itr_gate_tb.sv
module dbg_itr_gate_tb;
  logic clk = 0, rst_n = 0;
  logic dbg_wr = 0, dbg_mmap = 0, stat_lock = 0, stat_oslock = 0, stat_pwr = 1;
  logic sw_lock = 0, core_halted = 1, mem_acc_mode = 0, cmp_mode = 0, clr_strobe = 0;
  logic core_done = 0, core_abort = 0;
  logic [31:0] dbg_wdata = 0;
  logic dbg_wr_err, core_issue_valid, core_issue_part, itr_ready, itr_ovr, itr_err;
  logic [31:0] core_issue_word;

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;

  // behavioural model
  bit m_valid = 0, m_part = 0, m_cmp = 0, m_ready = 1, m_ovr = 0, m_err = 0;
  int unsigned m_word = 0;

  always #2.5 clk = ~clk;

  dbg_itr_gate u_dut (.*);

  always @(posedge clk) begin
    bit good, drop, ovr_ev, iss, n_ready, n_err, n_ovr;
    if (!rst_n) begin
      m_valid = 0; m_part = 0; m_cmp = 0; m_ready = 1; m_ovr = 0; m_err = 0;
    end else begin
      good   = (stat_lock == 0) && (stat_oslock == 0) && (stat_pwr == 1);
      drop   = m_err || (dbg_mmap && sw_lock) || !core_halted;
      ovr_ev = dbg_wr && good && !drop && (!m_ready || mem_acc_mode);
      iss    = dbg_wr && good && !drop && !ovr_ev;
      n_ready = m_ready; n_err = m_err; n_ovr = m_ovr;
      if (clr_strobe) begin n_err = 0; n_ovr = 0; end
      if (m_valid && core_done) begin
        if (core_abort) begin n_err = 1; m_valid = 0; n_ready = 1; end
        else if (m_cmp && !m_part) m_part = 1;
        else begin m_valid = 0; n_ready = 1; end
      end
      if (ovr_ev) begin n_ovr = 1; n_err = 1; end
      if (iss) begin
        m_valid = 1; m_part = 0; m_word = dbg_wdata; m_cmp = cmp_mode; n_ready = 0;
      end
      m_ready = n_ready; m_err = n_err; m_ovr = n_ovr;
    end
  end

  function automatic int unsigned exp_word();
    if (!m_valid) return 0;
    if (!m_cmp) return m_word;
    return (m_word >> (m_part ? 16 : 0)) % 65536;
  endfunction

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    bit exp_berr;
    cycles++;
    if (rst_n) begin
      exp_berr = dbg_wr && !((stat_lock == 0) && (stat_oslock == 0) && (stat_pwr == 1));
      chk(dbg_wr_err == exp_berr, "R1 bus error", dbg_wr_err, exp_berr);
      chk(core_issue_valid == m_valid, "R5 issue valid", core_issue_valid, m_valid);
      chk(core_issue_word == exp_word(), "R6/R7 issue word", core_issue_word, exp_word());
      chk(core_issue_part == (m_valid && m_part), "R7 part", core_issue_part, m_part);
      chk(itr_ready == m_ready, "R5/R8 ready", itr_ready, m_ready);
      chk(itr_ovr == m_ovr, "R4/R9 overrun", itr_ovr, m_ovr);
      chk(itr_err == m_err, "R4/R8/R9 error", itr_err, m_err);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    dbg_wr = 0; core_done = 0; core_abort = 0; clr_strobe = 0;
  endtask

  task automatic wr(input logic [31:0] d, input bit mm);
    dbg_wr = 1; dbg_wdata = d; dbg_mmap = mm;
    tick();
    dbg_mmap = 0;
  endtask

  task automatic done(input bit ab);
    core_done = 1; core_abort = ab;
    tick();
  endtask

  task automatic clr();
    clr_strobe = 1;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(itr_ready == 1 && itr_err == 0 && itr_ovr == 0 && core_issue_valid == 0,
        "R10 reset state", {itr_ready, itr_err, itr_ovr, core_issue_valid}, 4'b1000);
    rst_n = 1;
    tick();
    done(0);                                   // R10 stray done ignored
    chk(core_issue_valid == 0 && itr_ready == 1, "R10 stray done", core_issue_valid, 0);
    // R6 full word
    wr(32'hCAFE_1234, 0);
    chk(core_issue_word == 32'hCAFE_1234, "R6 full word", core_issue_word, 32'hCAFE_1234);
    tick(); tick();                            // R11 hold
    done(0);
    chk(itr_ready == 1, "R6 ready after done", itr_ready, 1);
    // R7 compressed
    cmp_mode = 1;
    wr(32'hBEEF_5A5A, 0);
    chk(core_issue_word == 32'h0000_5A5A, "R7 low half first", core_issue_word, 32'h5A5A);
    done(0);
    chk(core_issue_word == 32'h0000_BEEF && core_issue_part, "R7 high half", core_issue_word, 32'hBEEF);
    done(0);
    chk(core_issue_valid == 0, "R7 finished", core_issue_valid, 0);
    // R8 abort on first half
    wr(32'h1111_2222, 0);
    done(1);
    chk(itr_err == 1 && itr_ready == 1 && core_issue_valid == 0, "R8 abort", itr_err, 1);
    cmp_mode = 0;
    // R2 error sticky drops write
    wr(32'h3333_4444, 0);
    chk(core_issue_valid == 0, "R2 drop on sticky error", core_issue_valid, 0);
    clr();
    chk(itr_err == 0, "R9 clear", itr_err, 0);
    // R2 software lock
    sw_lock = 1;
    wr(32'h5555_6666, 1);
    chk(core_issue_valid == 0, "R2 drop on software lock", core_issue_valid, 0);
    wr(32'h7777_8888, 0);                      // non-mapped path ignores sw lock
    chk(core_issue_valid == 1, "R2 non-mapped accepted", core_issue_valid, 1);
    sw_lock = 0;
    // R4 overrun while busy
    wr(32'h9999_AAAA, 0);
    chk(itr_ovr == 1 && itr_err == 1, "R4 overrun busy", {itr_ovr, itr_err}, 2'b11);
    chk(core_issue_word == 32'h7777_8888, "R4 word kept", core_issue_word, 32'h7777_8888);
    done(0);
    clr();
    // R4 memory-access mode
    mem_acc_mode = 1;
    wr(32'h0BAD_0BAD, 0);
    chk(itr_ovr == 1 && core_issue_valid == 0, "R4 mem access overrun", itr_ovr, 1);
    mem_acc_mode = 0;
    // R9 clear and set together: set wins
    clr();
    wr(32'h0000_0001, 0);
    mem_acc_mode = 1;
    dbg_wr = 1; clr_strobe = 1; tick();
    mem_acc_mode = 0;
    chk(itr_ovr == 1 && itr_err == 1, "R9 set beats clear", itr_ovr, 1);
    done(0); clr();
    // R3 not halted
    core_halted = 0;
    wr(32'h1234_5678, 0);
    chk(core_issue_valid == 0 && itr_ovr == 0, "R3 not halted", core_issue_valid, 0);
    core_halted = 1;
    // R1 bad status combinations
    for (int k = 0; k < 8; k++) begin
      if (k == 1) continue;
      {stat_lock, stat_oslock, stat_pwr} = 3'(k);
      dbg_wr = 1; dbg_wdata = 32'hDEAD_0000 + k;
      #1;
      chk(dbg_wr_err == 1, "R1 status reject", dbg_wr_err, 1);
      tick();
      chk(core_issue_valid == 0 && itr_err == 0, "R1 no side effect", core_issue_valid, 0);
    end
    {stat_lock, stat_oslock, stat_pwr} = 3'b001;
    wr(32'hF00D_F00D, 0);
    chk(core_issue_valid == 1 && dbg_wr_err == 0, "R5 accept after status ok", core_issue_valid, 1);
    done(0);
    tick(); tick();
    done_flag = 1;
  end

  initial begin
    wait (done_flag || cycles > 20000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule